// File: doc/BRIEF.md
# Single-Cycle Load-Store RISC Core

This block is a small processor that completes one 32-bit instruction per clock. It supports five operations: word load, word store, subtract, signed set-less-than and branch-on-equal. It contains a register file of 32 words, each 32 bits wide, and register zero is fixed at zero. It also holds one word-addressed array for instructions and one for data. The only memory addressing mode is a base register plus a sign-extended 16-bit displacement.

A host fills both arrays through a load port while the core is parked (`run` low). The host then raises `run` and the core executes from address zero. Execution continues until the core fetches the all-ones word, which stops it and raises `done`. After that the host reads any register or data word through two registered inspection ports. A typical program loads two words, compares them, branches on the result and stores a difference.

Top module: `lsr_core`

## Requirements
- R1: Instruction fields are fixed. Bits 31:26 are the opcode. Bits 25:21 are source A. Bits 20:16 are source B, or the load destination. Bits 15:11 are the register-form destination. Bits 5:0 are the register-form function. Bits 15:0 are the immediate. Opcode 100011 loads the data word at index (A + sign-extended immediate)[MEM_AW+1:2] into register B. A negative displacement reaches below the base.
- R2: Opcode 101011 stores register B into the data word at index (A + sign-extended immediate)[MEM_AW+1:2].
- R3: Opcode 000000 with function 100010 writes A − B to the destination, wrapping modulo 2^32 without any trap.
- R4: Opcode 000000 with function 101010 writes 1 to the destination when A < B as signed values, and 0 otherwise.
- R5: Opcode 000100 compares A and B. When they are equal the PC becomes PC + 4 + (sign-extended immediate << 2). Otherwise the PC becomes PC + 4. The PC is always a multiple of 4, and there is no delay slot.
- R6: Register 0 always reads as zero, and writes to it are discarded.
- R7: The word 32'hFFFFFFFF halts the core. `done` rises, the PC stays on the halt word, and both hold until reset.
- R8: A synchronous reset clears the PC, every register and `done`.
- R9: Any other encoding changes no register and no data word, and the PC advances by 4.
- R10: Host writes through `ld_*` take effect only while `run` is low. `ld_sel` = 0 selects the instruction array and `ld_sel` = 1 selects the data array. Both inspection outputs show the selected item one clock after the address is applied.
- R11: While `run` is low, the PC does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Execute one instruction per clock while high |
| ld_we | input | 1 | Host write strobe (honoured only with run low) |
| ld_sel | input | 1 | 0 = instruction array, 1 = data array |
| ld_addr | input | MEM_AW | Host word index |
| ld_wdata | input | 32 | Host write data |
| peek_reg | input | 5 | Register index to inspect |
| peek_reg_data | output | 32 | Registered value of the inspected register |
| peek_mem_addr | input | MEM_AW | Data word index to inspect |
| peek_mem_data | output | 32 | Registered value of the inspected data word |
| pc_o | output | 32 | Current program counter (byte address) |
| done | output | 1 | Halt word reached |

## Verification
A table of operand pairs drives an absolute-difference program through both branch directions. The pairs include equal operands, sign-crossing values and the most negative word. A core that compares unsigned, or that computes the branch target without the +4 or the shift, ends with a wrong stored result, a wrong final PC or a wrong cycle count. A directed program uses a negative displacement, an unknown opcode, and a load into register zero followed by a store of that register. A core that mis-extends the immediate, executes unknown opcodes or lets register zero be written leaves a visibly wrong register or data word. Further checks confirm that the halt freezes the PC, that host writes during a run are refused and that reset wipes the registers.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int ILEN = 32;
  localparam int RAW  = 5;

  localparam logic [5:0] OPC_REG   = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] FN_SUB    = 6'b100010;
  localparam logic [5:0] FN_SLT    = 6'b101010;
  localparam logic [ILEN-1:0] HALT_WORD = '1;

  typedef enum logic [2:0] {
    K_NOP, K_LOAD, K_STORE, K_SUB, K_SLT, K_BEQ, K_HALT
  } kind_e;

  typedef struct packed {
    kind_e           kind;
    logic [RAW-1:0]  ra;
    logic [RAW-1:0]  rb;
    logic [RAW-1:0]  rd;
    logic [ILEN-1:0] imm;
  } dec_t;
endpackage

// File: rtl/lsr_decode.sv
module lsr_decode
  import lsr_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  output dec_t            dec
);
  logic [5:0] opc;
  logic [5:0] fn;
  logic [4:0] unused_shamt;

  assign opc          = instr[31:26];
  assign fn           = instr[5:0];
  assign unused_shamt = instr[10:6];

  always_comb begin
    dec.ra  = instr[25:21];
    dec.rb  = instr[20:16];
    dec.rd  = instr[15:11];
    dec.imm = {{(ILEN-16){instr[15]}}, instr[15:0]};
    dec.kind = K_NOP;
    if (instr == HALT_WORD) begin
      dec.kind = K_HALT;
    end else begin
      case (opc)
        OPC_LOAD:  dec.kind = K_LOAD;
        OPC_STORE: dec.kind = K_STORE;
        OPC_BEQ:   dec.kind = K_BEQ;
        OPC_REG: begin
          if (fn == FN_SUB)      dec.kind = K_SUB;
          else if (fn == FN_SLT) dec.kind = K_SLT;
          else                   dec.kind = K_NOP;
        end
        default:   dec.kind = K_NOP;
      endcase
    end
  end
endmodule

// File: rtl/lsr_regfile.sv
module lsr_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra1,
  output logic [DW-1:0] rd1,
  input  logic [AW-1:0] ra2,
  output logic [DW-1:0] rd2,
  input  logic [AW-1:0] ra3,
  output logic [DW-1:0] rd3
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  // index zero is never written, but the read side also forces zero
  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
  assign rd3 = (ra3 == '0) ? '0 : regs[ra3];
endmodule

// File: rtl/lsr_alu.sv
module lsr_alu
  import lsr_pkg::*;
#(
  parameter int DW = 32
) (
  input  kind_e         kind,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic          equal
);
  logic [DW-1:0] diff;
  logic          lt;

  assign diff  = a - b;
  assign lt    = $signed(a) < $signed(b);
  assign equal = (a == b);

  always_comb begin
    case (kind)
      K_SLT:   res = {{(DW-1){1'b0}}, lt};
      default: res = diff;
    endcase
  end
endmodule

// File: rtl/lsr_core.sv
module lsr_core
  import lsr_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              ld_we,
  input  logic              ld_sel,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [31:0]       ld_wdata,
  input  logic [4:0]        peek_reg,
  output logic [31:0]       peek_reg_data,
  input  logic [MEM_AW-1:0] peek_mem_addr,
  output logic [31:0]       peek_mem_data,
  output logic [31:0]       pc_o,
  output logic              done
);
  localparam int WORDS = 1 << MEM_AW;
  localparam int IDX_HI = MEM_AW + 1;

  logic [ILEN-1:0] imem [WORDS];
  logic [ILEN-1:0] dmem [WORDS];

  logic [ILEN-1:0] pc_q;
  logic            done_q;
  logic [ILEN-1:0] instr;
  dec_t            dec;
  logic [ILEN-1:0] va, vb, vpeek;
  logic [ILEN-1:0] alu_res;
  logic            alu_eq;
  logic [ILEN-1:0] ea;
  logic [ILEN-1:0] ld_val;
  logic            exec;
  logic            rf_we;
  logic [RAW-1:0]  rf_waddr;
  logic [ILEN-1:0] rf_wdata;
  logic            dm_core_we;
  logic            host_ok;
  logic [ILEN-1:0] pc_seq;
  logic [ILEN-1:0] pc_next;
  logic            unused_bits;

  assign instr = imem[pc_q[IDX_HI:2]];

  lsr_decode u_dec (.instr(instr), .dec(dec));

  lsr_regfile #(.DW(ILEN), .NREG(1 << RAW)) u_rf (
    .clk(clk), .rst(rst),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra1(dec.ra), .rd1(va),
    .ra2(dec.rb), .rd2(vb),
    .ra3(peek_reg), .rd3(vpeek)
  );

  lsr_alu #(.DW(ILEN)) u_alu (
    .kind(dec.kind), .a(va), .b(vb), .res(alu_res), .equal(alu_eq)
  );

  assign ea     = va + dec.imm;
  assign ld_val = dmem[ea[IDX_HI:2]];
  assign unused_bits = ^{ea[ILEN-1:IDX_HI+1], ea[1:0], pc_q[ILEN-1:IDX_HI+1], pc_q[1:0]};

  assign exec       = run && !done_q;
  assign host_ok    = ld_we && !run;
  assign rf_we      = exec && (dec.kind inside {K_LOAD, K_SUB, K_SLT});
  assign rf_waddr   = (dec.kind == K_LOAD) ? dec.rb : dec.rd;
  assign rf_wdata   = (dec.kind == K_LOAD) ? ld_val : alu_res;
  assign dm_core_we = exec && (dec.kind == K_STORE);

  assign pc_seq = pc_q + 32'd4;
  always_comb begin
    pc_next = pc_seq;
    if (dec.kind == K_HALT)
      pc_next = pc_q;
    else if ((dec.kind == K_BEQ) && alu_eq)
      pc_next = pc_seq + {dec.imm[ILEN-3:0], 2'b00};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      done_q <= 1'b0;
    end else if (exec) begin
      pc_q <= pc_next;
      if (dec.kind == K_HALT) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (host_ok && !ld_sel) imem[ld_addr] <= ld_wdata;
  end

  always_ff @(posedge clk) begin
    if (dm_core_we)
      dmem[ea[IDX_HI:2]] <= vb;
    else if (host_ok && ld_sel)
      dmem[ld_addr] <= ld_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      peek_reg_data <= '0;
      peek_mem_data <= '0;
    end else begin
      peek_reg_data <= vpeek;
      peek_mem_data <= dmem[peek_mem_addr];
    end
  end

  assign pc_o = pc_q;
  assign done = done_q;
endmodule

// File: rtl/lsr_core_chk.sv
module lsr_core_chk (
  input logic        clk,
  input logic        rst,
  input logic        run,
  input logic        done,
  input logic [31:0] pc_o,
  input logic [4:0]  peek_reg,
  input logic [31:0] peek_reg_data
);
  a_r7_pc_frozen: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(pc_o));

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(pc_o));

  a_r6_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (peek_reg == 5'd0) |=> (peek_reg_data == 32'd0));

  a_r8_reset: assert property (@(posedge clk)
    rst |=> (pc_o == 32'd0 && !done));

  a_r5_pc_aligned: assert property (@(posedge clk) disable iff (rst)
    pc_o[1:0] == 2'b00);
endmodule

bind lsr_core lsr_core_chk u_chk (
  .clk(clk), .rst(rst), .run(run), .done(done), .pc_o(pc_o),
  .peek_reg(peek_reg), .peek_reg_data(peek_reg_data)
);

// File: tb/sim_lsr_core.sv
module sim_lsr_core;
  localparam int AW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          run = 1'b0;
  logic          ld_we = 1'b0;
  logic          ld_sel = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_wdata = '0;
  logic [4:0]    peek_reg = '0;
  logic [31:0]   peek_reg_data;
  logic [AW-1:0] peek_mem_addr = '0;
  logic [31:0]   peek_mem_data;
  logic [31:0]   pc_o;
  logic          done;

  lsr_core #(.MEM_AW(AW)) u0 (
    .clk(clk), .rst(rst), .run(run), .ld_we(ld_we), .ld_sel(ld_sel),
    .ld_addr(ld_addr), .ld_wdata(ld_wdata), .peek_reg(peek_reg),
    .peek_reg_data(peek_reg_data), .peek_mem_addr(peek_mem_addr),
    .peek_mem_data(peek_mem_data), .pc_o(pc_o), .done(done)
  );

  // absolute-difference program: c = (a <= b) ? a - b : b - a
  localparam logic [31:0] PROG_A [9] = '{
    32'h8C080004, 32'h8C090008, 32'h0128502A, 32'h11400002,
    32'h01285822, 32'h10000001, 32'h01095822, 32'hAC0B000C, 32'hFFFFFFFF };
  // negative displacement, unknown opcode, write to r0, wrapping subtract
  localparam logic [31:0] PROG_B [7] = '{
    32'h8C030008, 32'h8C62FFFC, 32'h20010005, 32'h8C000004,
    32'hAC000014, 32'h00032022, 32'hFFFFFFFF };

  localparam int NV = 7;
  localparam logic [31:0] VA [NV] = '{32'd5, 32'd9, 32'd7, 32'hFFFFFFFD,
                                     32'd2, 32'h80000000, 32'h7FFFFFFF};
  localparam logic [31:0] VB [NV] = '{32'd9, 32'd4, 32'd7, 32'd2,
                                     32'hFFFFFFFD, 32'd1, 32'h80000000};
  localparam logic [31:0] VC [NV] = '{32'hFFFFFFFC, 32'hFFFFFFFB, 32'd0, 32'hFFFFFFFB,
                                     32'hFFFFFFFB, 32'h7FFFFFFF, 32'd1};
  localparam int VN [NV] = '{7, 8, 7, 7, 8, 7, 8};

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic host_wr(input logic sel, input int addr, input logic [31:0] data);
    ld_we = 1'b1; ld_sel = sel; ld_addr = AW'(addr); ld_wdata = data;
    tick();
    ld_we = 1'b0;
  endtask

  task automatic peek_r(input int idx, output logic [31:0] v);
    peek_reg = 5'(idx);
    tick();
    v = peek_reg_data;
  endtask

  task automatic peek_m(input int idx, output logic [31:0] v);
    peek_mem_addr = AW'(idx);
    tick();
    v = peek_mem_data;
  endtask

  task automatic run_to_done(output int cyc);
    cyc = 0;
    run = 1'b1;
    for (int k = 0; k < 60; k++) begin
      tick();
      cyc++;
      if (done) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cyc;
    @(negedge clk); tick();
    rst = 1'b0;
    // R8 reset state
    check("R8 pc after reset", pc_o, 32'd0);
    check("R8 done after reset", {31'd0, done}, 32'd0);
    peek_r(8, v);
    check("R8 reg cleared", v, 32'd0);
    // R11 idle hold
    repeat (3) tick();
    check("R11 pc held while parked", pc_o, 32'd0);

    // table-driven absolute difference runs
    for (int i = 0; i < NV; i++) begin
      rst = 1'b1; run = 1'b0;
      for (int j = 0; j < 9; j++) host_wr(1'b0, j, PROG_A[j]);
      host_wr(1'b1, 1, VA[i]);
      host_wr(1'b1, 2, VB[i]);
      host_wr(1'b1, 3, 32'hDEADBEEF);
      rst = 1'b0;
      tick();
      run_to_done(cyc);
      run = 1'b0;
      check("R7 done raised", {31'd0, done}, 32'd1);
      check("R5 branch path cycles", 32'(cyc), 32'(VN[i]));
      check("R5 final pc", pc_o, 32'd32);
      peek_m(3, v);
      check("R2 R3 stored difference", v, VC[i]);
      peek_r(10, v);
      check("R4 slt flag", v, {31'd0, ($signed(VB[i]) < $signed(VA[i]))});
      peek_r(8, v);
      check("R1 loaded word", v, VA[i]);
    end

    // directed program
    rst = 1'b1; run = 1'b0;
    for (int j = 0; j < 7; j++) host_wr(1'b0, j, PROG_B[j]);
    host_wr(1'b1, 1, 32'h12345678);
    host_wr(1'b1, 2, 32'd20);
    host_wr(1'b1, 4, 32'hCAFEF00D);
    host_wr(1'b1, 5, 32'h00000055);
    rst = 1'b0;
    tick();
    run_to_done(cyc);
    check("R7 halt cycles", 32'(cyc), 32'd7);
    check("R7 halt pc", pc_o, 32'd24);
    peek_r(2, v);
    check("R1 negative displacement", v, 32'hCAFEF00D);
    peek_r(1, v);
    check("R9 unknown opcode writes nothing", v, 32'd0);
    peek_r(0, v);
    check("R6 r0 stays zero", v, 32'd0);
    peek_m(5, v);
    check("R6 R2 stored r0 value", v, 32'd0);
    peek_r(4, v);
    check("R3 wrap subtract", v, 32'hFFFFFFEC);
    // still running after halt: pc frozen, host write refused
    repeat (3) tick();
    check("R7 pc frozen", pc_o, 32'd24);
    check("R7 done held", {31'd0, done}, 32'd1);
    host_wr(1'b1, 5, 32'h00000099);
    peek_m(5, v);
    check("R10 host write refused while running", v, 32'd0);
    run = 1'b0;
    host_wr(1'b1, 6, 32'h00000077);
    peek_m(6, v);
    check("R10 host write accepted when parked", v, 32'h00000077);
    // reset wipes state
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R8 pc cleared", pc_o, 32'd0);
    check("R8 done cleared", {31'd0, done}, 32'd0);
    peek_r(2, v);
    check("R8 register cleared", v, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule